// File: doc/BRIEF.md
# Bitplane Fetch Slot Scheduler

This block decides, slot by slot along a scan line, which display plane owns the memory bus. The horizontal position advances one slot per clock. When it equals the programmed fetch-start value, an enable token enters a chain of registered stages. When the token leaves the chain, a group of eight fetch slots begins. Each slot of the group belongs to one plane in a fixed interleaved order, or to no plane. A slot whose plane is not enabled by the active-plane count is left free, and other bus users such as the display coprocessor can take it.

Groups follow one another without gaps. Once the position has reached the fetch-stop value, the group in progress runs to its end and fetching stops for the rest of the line. A line-start pulse clears all state, so that nothing carries over from one line to the next. The outputs are plain per-cycle control signals that the bus arbiter reads. There is no handshake and no back-pressure, because a slot cannot be delayed.

Top module: `bpl_slot_sched`

## Requirements
- R1: While reset is held, and on every line before its first slot, `slot_plane_o` is 0 and `slot_steal_o` is 0.
- R2: If `hpos_i` equals `fetch_start_i` in cycle t, slot 0 of the first group appears in cycle t+4, when `hpos_i` is start+4. Every earlier position on that line shows no plane.
- R3: Slot indices 0 to 7 of a group map to planes 8, 4, 6, 2, none, 3, 5 and 1, in that order. `slot_plane_o` gives the plane number (1 to 8) and uses 0 for none.
- R4: Slot index 4 of every group is always free: the plane output is 0 and the steal flag is 0.
- R5: A slot shows its plane only when that plane number is at most the active plane count. `slot_steal_o` is 1 exactly when `slot_plane_o` is non-zero.
- R6: A `plane_count_i` of 0 gives no fetch at all. Values from 9 to 15 act as 8.
- R7: A new group starts immediately after each group ends. In the first group that is in progress, or still pending, when `hpos_i` equals `fetch_stop_i`, all eight slots are issued. After that group, no slot is issued for the rest of the line.
- R8: A `line_start_i` pulse forces no-plane in its own cycle. It also clears any group in progress and any pending enable token, so the new line shows no plane until its own start delay has run out. A start match in the same cycle as the pulse is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock; one horizontal position per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_start_i | input | 1 | One-cycle pulse at the first position of each line |
| hpos_i | input | HPOS_W | Current horizontal position |
| fetch_start_i | input | HPOS_W | Position whose match arms fetching |
| fetch_stop_i | input | HPOS_W | Position after which the current group is the last |
| plane_count_i | input | 4 | Number of active planes, 0 to 8 (larger values saturate) |
| slot_plane_o | output | 4 | Plane that owns this slot, 0 for a free slot |
| slot_steal_o | output | 1 | Slot is taken from other bus users |

## Verification
Each line compares every position against an arithmetic model. The sweep covers all sixteen plane-count codes against several start/stop pairs. A wide window that ends mid-line tests group repetition and the fixed slot order. A window whose stop equals its start tests that a stop seen during the start delay still lets exactly one group run. Stops that fall inside a group, or on its last slot, show whether the group is completed or cut short. A window with start at position 0 tests a start match in the line-start cycle. A window that never reaches its stop is followed by another line, which shows that the line-start pulse removes the open group. Counts 0 and 9 to 15 separate the disabled case and saturation from a plain compare.

// File: rtl/bpl_sched_pkg.sv
package bpl_sched_pkg;

  localparam int GROUP_SLOTS = 8;
  localparam int SLOT_W      = $clog2(GROUP_SLOTS);
  localparam int PLANE_W     = 4;
  localparam int MAX_PLANES  = 8;

  // Fixed interleave of one group; 0 marks a slot left to other users.
  function automatic logic [PLANE_W-1:0] slot_to_plane(input logic [SLOT_W-1:0] idx);
    logic [PLANE_W-1:0] p;
    case (idx)
      3'd0: p = 4'd8;
      3'd1: p = 4'd4;
      3'd2: p = 4'd6;
      3'd3: p = 4'd2;
      3'd4: p = 4'd0;
      3'd5: p = 4'd3;
      3'd6: p = 4'd5;
      default: p = 4'd1;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/bpl_start_pipe.sv
module bpl_start_pipe #(
  parameter int HPOS_W   = 9,
  parameter int EN_DELAY = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [HPOS_W-1:0] hpos_i,
  input  logic [HPOS_W-1:0] fetch_start_i,
  output logic              started_o,
  output logic              launch_o
);

  logic                taken_q;
  logic                match;
  logic [EN_DELAY-1:0] stage_q;

  // One match per line; a pulse re-arms in the same cycle.
  assign match     = (hpos_i == fetch_start_i) && (line_start_i || !taken_q);
  assign started_o = match || (taken_q && !line_start_i);
  assign launch_o  = stage_q[EN_DELAY-1] && !line_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q <= 1'b0;
    end else if (line_start_i) begin
      taken_q <= match;
    end else begin
      taken_q <= taken_q | match;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= 1'b0;
    else         stage_q[0] <= match;
  end

  for (genvar i = 1; i < EN_DELAY; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           stage_q[i] <= 1'b0;
      else if (line_start_i) stage_q[i] <= 1'b0;
      else                   stage_q[i] <= stage_q[i-1];
    end
  end

  // R2: a launch is only possible after a match earlier on this line
  launch_after_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> taken_q);

endmodule

// File: rtl/bpl_group_seq.sv
module bpl_group_seq
  import bpl_sched_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic              launch_i,
  input  logic              stop_hit_i,
  output logic              active_o,
  output logic [SLOT_W-1:0] slot_idx_o
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_SLOTS - 1);

  logic              running_q;
  logic              stop_seen_q;
  logic [SLOT_W-1:0] cnt_q;
  logic              stop_now;

  assign stop_now   = stop_seen_q || stop_hit_i;
  assign active_o   = (launch_i || running_q) && !line_start_i;
  assign slot_idx_o = launch_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q   <= 1'b0;
      stop_seen_q <= 1'b0;
      cnt_q       <= '0;
    end else if (line_start_i) begin
      running_q   <= 1'b0;
      stop_seen_q <= 1'b0;
      cnt_q       <= '0;
    end else begin
      stop_seen_q <= stop_now;
      if (active_o) begin
        cnt_q     <= slot_idx_o + 1'b1;
        running_q <= !((slot_idx_o == LAST_SLOT) && stop_now);
      end
    end
  end

  // R7: a group, once begun, is never cut short within a line
  group_complete_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && slot_idx_o != LAST_SLOT) ##1 !line_start_i
      |-> active_o && slot_idx_o == SLOT_W'($past(slot_idx_o) + 1'b1));

  // R7: the first group begins at slot 0
  launch_slot0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && !line_start_i) |-> (active_o && slot_idx_o == '0));

endmodule

// File: rtl/bpl_slot_decode.sv
module bpl_slot_decode
  import bpl_sched_pkg::*;
(
  input  logic               active_i,
  input  logic [SLOT_W-1:0]  slot_idx_i,
  input  logic [PLANE_W-1:0] plane_count_i,
  output logic [PLANE_W-1:0] plane_o,
  output logic               steal_o
);

  logic [PLANE_W-1:0] eff_count;
  logic [PLANE_W-1:0] slot_plane;

  assign eff_count  = (plane_count_i > PLANE_W'(MAX_PLANES)) ? PLANE_W'(MAX_PLANES)
                                                              : plane_count_i;
  assign slot_plane = slot_to_plane(slot_idx_i);

  always_comb begin
    plane_o = '0;
    if (active_i && slot_plane != '0 && slot_plane <= eff_count) plane_o = slot_plane;
    steal_o = (plane_o != '0);
  end

endmodule

// File: rtl/bpl_slot_sched.sv
module bpl_slot_sched
  import bpl_sched_pkg::*;
#(
  parameter int HPOS_W   = 9,
  parameter int EN_DELAY = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_start_i,
  input  logic [HPOS_W-1:0]  hpos_i,
  input  logic [HPOS_W-1:0]  fetch_start_i,
  input  logic [HPOS_W-1:0]  fetch_stop_i,
  input  logic [3:0]         plane_count_i,
  output logic [3:0]         slot_plane_o,
  output logic               slot_steal_o
);

  logic              started;
  logic              launch;
  logic              stop_hit;
  logic              active;
  logic [SLOT_W-1:0] slot_idx;

  bpl_start_pipe #(.HPOS_W(HPOS_W), .EN_DELAY(EN_DELAY)) u_start (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .line_start_i  (line_start_i),
    .hpos_i        (hpos_i),
    .fetch_start_i (fetch_start_i),
    .started_o     (started),
    .launch_o      (launch)
  );

  assign stop_hit = started && (hpos_i == fetch_stop_i);

  bpl_group_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .launch_i     (launch),
    .stop_hit_i   (stop_hit),
    .active_o     (active),
    .slot_idx_o   (slot_idx)
  );

  bpl_slot_decode u_dec (
    .active_i      (active),
    .slot_idx_i    (slot_idx),
    .plane_count_i (plane_count_i),
    .plane_o       (slot_plane_o),
    .steal_o       (slot_steal_o)
  );

  // R5
  plane_within_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_steal_o |-> (slot_plane_o != 4'd0 && slot_plane_o <= plane_count_i));

  // R4
  free_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && slot_idx == SLOT_W'(4)) |-> !slot_steal_o);

  // R8
  line_start_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |-> (slot_plane_o == 4'd0));

  // R6
  count_zero_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plane_count_i == 4'd0) |-> !slot_steal_o);

endmodule

// File: tb/bpl_slot_sched_tb.sv
`timescale 1ns/1ps
module bpl_slot_sched_tb;

  localparam int HPOS_W   = 9;
  localparam int LINE_LEN = 227;
  localparam int NPAIR    = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              line_start = 1'b0;
  logic [HPOS_W-1:0] hpos = '0;
  logic [HPOS_W-1:0] fstart = '0;
  logic [HPOS_W-1:0] fstop = '0;
  logic [3:0]        pcount = '0;
  logic [3:0]        plane;
  logic              steal;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bpl_slot_sched u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .line_start_i  (line_start),
    .hpos_i        (hpos),
    .fetch_start_i (fetch_start_sel()),
    .fetch_stop_i  (fstop),
    .plane_count_i (pcount),
    .slot_plane_o  (plane),
    .slot_steal_o  (steal)
  );

  function automatic logic [HPOS_W-1:0] fetch_start_sel();
    return fstart;
  endfunction

  function automatic int tab(input int k);
    case (k)
      0: return 8; 1: return 4; 2: return 6; 3: return 2;
      4: return 0; 5: return 3; 6: return 5; default: return 1;
    endcase
  endfunction

  // Expected plane for position h on a line with start s, stop p, count c.
  function automatic int exp_plane(input int h, input int s, input int p, input int c);
    int l, k, g, gstop, eff, pl;
    l = s + 4;
    if (h < l) return 0;
    k = h - l;
    g = k / 8;
    if (p >= LINE_LEN)      gstop = 1000;
    else if (p <= l + 7)    gstop = 0;
    else                    gstop = (p - l - 7 + 7) / 8;
    if (g > gstop) return 0;
    eff = (c > 8) ? 8 : c;
    pl  = tab(k % 8);
    return (pl != 0 && pl <= eff) ? pl : 0;
  endfunction

  function automatic string tag_of(input int h, input int s, input int p, input int c,
                                   input bit prev_open);
    int l, k;
    l = s + 4;
    if (h < l) return prev_open ? "R8" : "R2";
    if (h == l) return "R2";
    k = h - l;
    if (c == 0 || c > 8) return "R6";
    if (k % 8 == 4) return "R4";
    if (exp_plane(h, s, p, 8) == 0) return "R7";
    return "R3";
  endfunction

  task automatic check(input string tag, input int exp_p);
    n_cmp++;
    if (plane !== 4'(exp_p)) begin
      n_bad++;
      $display("FAIL %s plane: actual %0d expected %0d (hpos %0d)", tag, plane, exp_p, hpos);
    end
    n_cmp++;
    if (steal !== (exp_p != 0)) begin
      n_bad++;
      $display("FAIL R5 steal: actual %0d expected %0d (hpos %0d)", steal, exp_p != 0, hpos);
    end
  endtask

  task automatic run_line(input int s, input int p, input int c, input bit prev_open);
    for (int h = 0; h < LINE_LEN; h++) begin
      @(negedge clk);
      fstart     = HPOS_W'(s);
      fstop      = HPOS_W'(p);
      pcount     = 4'(c);
      hpos       = HPOS_W'(h);
      line_start = (h == 0);
      #1;
      check(tag_of(h, s, p, c, prev_open), exp_plane(h, s, p, c));
    end
  endtask

  initial begin
    int starts [NPAIR] = '{ 'h38, 'h18, 'h20, 'h00, 'h60, 'h30 };
    int stops  [NPAIR] = '{ 'hD0, 'h18, 'h2A, 'h4B, 'hF0, 'h31 };
    // R1: outputs quiet under reset even with a live start match
    fstart = 9'h005; fstop = 9'h080; pcount = 4'd8;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      hpos = 9'(i);
      #1;
      check("R1", 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 16; c++) begin
      for (int q = 0; q < NPAIR; q++) begin
        bit prev_open;
        prev_open = (q > 0) && (stops[q-1] >= LINE_LEN);
        run_line(starts[q], stops[q], c, prev_open);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule